// File: doc/BRIEF.md
# Next-PC and Branch Target Unit

This unit owns the program counter of a simple 32-bit processor and decides, every clock cycle, where the next instruction fetch goes. Each cycle it forms the sequential address (the current PC plus four), a PC-relative branch target, a region-relative jump target and a register-indirect target. It then loads one of them into the PC. The decoder supplies the instruction's immediate and index fields, a set of one-hot-ish control flags, the outcome of the register equality comparison, and the register value for indirect jumps.

For call instructions the unit also presents the return address, which is the current PC plus four, together with a write strobe and the fixed destination register number, so that the register file can record the link. An indirect jump whose target is not word aligned is refused. The PC keeps its value for that cycle and a fault flag is raised so that the surrounding core can trap.

Top module: `nextpc_unit`

## Requirements
- R1: While `rstN` is low, the PC is loaded with the reset vector, 0x00400000 by default. The first `pcOut` seen after reset is that value.
- R2: When no branch or jump flag is active, the PC increases by 4 on each rising clock edge.
- R3: The target of a taken branch is PC+4 plus the 16-bit `instrImm16` after sign extension and a left shift by two. Negative offsets move the PC backwards.
- R4: A branch with `isBeq` is taken only when `regsEqual` is 1. A branch with `isBne` is taken only when `regsEqual` is 0. An untaken branch advances the PC by 4.
- R5: The target of `isJump` or `isJal` is bits 31:28 of PC+4, followed by the 26-bit `instrIdx26`, followed by two zero bits. The top nibble therefore comes from PC+4 even when PC+4 crosses a 256 MiB boundary.
- R6: When `isJal` is accepted, `linkWrite` is 1 in that same cycle, `linkValue` equals `pcOut`+4 and `linkDest` is 31. The PC then loads the R5 target. At all other times `linkWrite` is 0.
- R7: When `isJr` is set and `regTarget[1:0]` is 00, the PC loads the full 32-bit `regTarget`.
- R8: When `isJr` is set and `regTarget[1:0]` is nonzero, `alignFault` is 1 in that cycle, the PC keeps its value on the next edge, and `linkWrite` is 0. `alignFault` is 0 whenever `isJr` is 0.
- R9: When several flags are set, `isJr` wins over `isJump`/`isJal`, which win over a taken branch, which wins over PC+4. A `isJal` that loses to `isJr` writes no link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| instrImm16 | input | 16 | Branch word offset field |
| instrIdx26 | input | 26 | Jump word index field |
| regsEqual | input | 1 | 1 when the two compared registers are equal |
| regTarget | input | 32 | Register value for indirect jumps |
| isBeq | input | 1 | Branch-if-equal instruction |
| isBne | input | 1 | Branch-if-not-equal instruction |
| isJump | input | 1 | Region-relative jump |
| isJal | input | 1 | Region-relative jump with link |
| isJr | input | 1 | Register-indirect jump |
| pcOut | output | 32 | Current program counter |
| linkValue | output | 32 | Return address (PC+4) |
| linkWrite | output | 1 | Link register write strobe |
| linkDest | output | 5 | Link register number (31) |
| alignFault | output | 1 | Misaligned indirect target flag |

## Verification
The properties assume that the decoder holds its flags and fields stable for a whole cycle. They also assume the flags change only between edges, so the value sampled at an edge is the instruction that edge executes. The bench meets this by driving every input on the falling edge and sampling registered results one time unit after the following rising edge. Where the properties compare the PC against a sum taken one cycle earlier, they rely on the core not changing `rstN` in the middle of an instruction. The bench asserts reset only while all flags are idle.

// File: rtl/npc_pkg.sv
package npc_pkg;
  // Strobes from the redirect control to the PC datapath
  typedef struct packed {
    logic takeJr;
    logic takeJump;
    logic takeBranch;
    logic holdPc;
  } npcStrobes_t;
endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic        isBeq,
  input  logic        isBne,
  input  logic        isJump,
  input  logic        isJal,
  input  logic        isJr,
  input  logic        regsEqual,
  input  logic [1:0]  targetLow,
  output npcStrobes_t strobes,
  output logic        writeLink,
  output logic        faultFlag
);
  logic branchTaken;
  logic jrMisaligned;
  logic anyJump;

  always_comb begin
    branchTaken  = (isBeq & regsEqual) | (isBne & ~regsEqual);
    jrMisaligned = isJr & (targetLow != 2'b00);
    anyJump      = isJump | isJal;

    strobes.takeJr     = isJr & ~jrMisaligned;
    strobes.holdPc     = jrMisaligned;
    strobes.takeJump   = anyJump & ~isJr;
    strobes.takeBranch = branchTaken & ~isJr & ~anyJump;

    writeLink = isJal & ~isJr;
    faultFlag = jrMisaligned;
  end
endmodule

// File: rtl/npc_datapath.sv
module npc_datapath
  import npc_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          OFF_W     = 16,
  parameter logic [31:0] RESET_VEC = 32'h0040_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  npcStrobes_t         strobes,
  input  logic [OFF_W-1:0]    offset,
  input  logic [ADDR_W-7:0]   jumpIndex,
  input  logic [ADDR_W-1:0]   regTarget,
  output logic [ADDR_W-1:0]   pcQ,
  output logic [ADDR_W-1:0]   pcPlus4
);
  localparam int SEXT_W = ADDR_W - OFF_W - 2;
  localparam int IDX_W  = ADDR_W - 6;

  logic [ADDR_W-1:0] branchTarget;
  logic [ADDR_W-1:0] jumpTarget;
  logic [ADDR_W-1:0] pcNext;

  always_comb begin
    pcPlus4      = pcQ + ADDR_W'(4);
    branchTarget = pcPlus4 + {{SEXT_W{offset[OFF_W-1]}}, offset, 2'b00};
    jumpTarget   = {pcPlus4[ADDR_W-1:ADDR_W-4], jumpIndex[IDX_W-1:0], 2'b00};
    if (strobes.holdPc)          pcNext = pcQ;
    else if (strobes.takeJr)     pcNext = regTarget;
    else if (strobes.takeJump)   pcNext = jumpTarget;
    else if (strobes.takeBranch) pcNext = branchTarget;
    else                         pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pcQ <= RESET_VEC[ADDR_W-1:0];
    else       pcQ <= pcNext;
  end
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import npc_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          OFF_W     = 16,
  parameter int          REG_IDX_W = 5,
  parameter int          LINK_REG  = 31,
  parameter logic [31:0] RESET_VEC = 32'h0040_0000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [OFF_W-1:0]      instrImm16,
  input  logic [ADDR_W-7:0]     instrIdx26,
  input  logic                  regsEqual,
  input  logic [ADDR_W-1:0]     regTarget,
  input  logic                  isBeq,
  input  logic                  isBne,
  input  logic                  isJump,
  input  logic                  isJal,
  input  logic                  isJr,
  output logic [ADDR_W-1:0]     pcOut,
  output logic [ADDR_W-1:0]     linkValue,
  output logic                  linkWrite,
  output logic [REG_IDX_W-1:0]  linkDest,
  output logic                  alignFault
);
  npcStrobes_t strobes;

  npc_ctrl ctrl_i (
    .isBeq     (isBeq),
    .isBne     (isBne),
    .isJump    (isJump),
    .isJal     (isJal),
    .isJr      (isJr),
    .regsEqual (regsEqual),
    .targetLow (regTarget[1:0]),
    .strobes   (strobes),
    .writeLink (linkWrite),
    .faultFlag (alignFault)
  );

  npc_datapath #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .RESET_VEC (RESET_VEC)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .offset    (instrImm16),
    .jumpIndex (instrIdx26),
    .regTarget (regTarget),
    .pcQ       (pcOut),
    .pcPlus4   (linkValue)
  );

  assign linkDest = REG_IDX_W'(LINK_REG);
endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] instrImm16,
  input logic [25:0] instrIdx26,
  input logic        regsEqual,
  input logic [31:0] regTarget,
  input logic        isBeq,
  input logic        isBne,
  input logic        isJump,
  input logic        isJal,
  input logic        isJr,
  input logic [31:0] pcOut,
  input logic [31:0] linkValue,
  input logic        linkWrite,
  input logic        alignFault
);
  logic idle;
  assign idle = !isBeq && !isBne && !isJump && !isJal && !isJr;

  // R2
  p_seq_advance_r2: assert property (@(posedge clk) disable iff (!rstN)
    idle |=> pcOut == $past(pcOut) + 32'd4);

  // R3 / R4
  p_beq_target_r3: assert property (@(posedge clk) disable iff (!rstN)
    (isBeq && regsEqual && !isJump && !isJal && !isJr) |=>
      pcOut == $past(pcOut) + 32'd4 + {{14{$past(instrImm16[15])}}, $past(instrImm16), 2'b00});

  // R4
  p_bne_untaken_r4: assert property (@(posedge clk) disable iff (!rstN)
    (isBne && !isBeq && regsEqual && !isJump && !isJal && !isJr) |=>
      pcOut == $past(pcOut) + 32'd4);

  // R5 / R6
  p_jump_target_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((isJump || isJal) && !isJr) |=>
      pcOut == {$past(linkValue[31:28]), $past(instrIdx26), 2'b00});

  // R6
  p_link_only_jal_r6: assert property (@(posedge clk) disable iff (!rstN)
    linkWrite |-> (isJal && !isJr));

  // R7
  p_jr_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    (isJr && regTarget[1:0] == 2'b00) |=> pcOut == $past(regTarget));

  // R8
  p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |=> $stable(pcOut));

  p_fault_src_r8: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> (isJr && !linkWrite));
endmodule

bind nextpc_unit nextpc_unit_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .instrImm16 (instrImm16),
  .instrIdx26 (instrIdx26),
  .regsEqual  (regsEqual),
  .regTarget  (regTarget),
  .isBeq      (isBeq),
  .isBne      (isBne),
  .isJump     (isJump),
  .isJal      (isJal),
  .isJr       (isJr),
  .pcOut      (pcOut),
  .linkValue  (linkValue),
  .linkWrite  (linkWrite),
  .alignFault (alignFault)
);

// File: tb/nextpc_unit_tb.sv
module nextpc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] instrImm16;
  logic [25:0] instrIdx26;
  logic        regsEqual;
  logic [31:0] regTarget;
  logic        isBeq, isBne, isJump, isJal, isJr;
  logic [31:0] pcOut;
  logic [31:0] linkValue;
  logic        linkWrite;
  logic [4:0]  linkDest;
  logic        alignFault;

  int total = 0;
  int bad   = 0;
  logic [31:0] expPc;

  always #4 clk = ~clk;

  nextpc_unit dut_i (
    .clk(clk), .rstN(rstN), .instrImm16(instrImm16), .instrIdx26(instrIdx26),
    .regsEqual(regsEqual), .regTarget(regTarget), .isBeq(isBeq), .isBne(isBne),
    .isJump(isJump), .isJal(isJal), .isJr(isJr), .pcOut(pcOut),
    .linkValue(linkValue), .linkWrite(linkWrite), .linkDest(linkDest),
    .alignFault(alignFault)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setIdle();
    isBeq = 0; isBne = 0; isJump = 0; isJal = 0; isJr = 0;
    regsEqual = 0; instrImm16 = '0; instrIdx26 = '0; regTarget = '0;
  endtask

  // Apply one instruction at a falling edge, expect new PC after the rising edge
  task automatic stepExpect(input string tag, input logic [31:0] nextPc);
    @(posedge clk); #1;
    chk(tag, pcOut, nextPc);
    expPc = nextPc;
    @(negedge clk);
    setIdle();
  endtask

  function automatic logic [31:0] brTarget(input logic [31:0] pc, input logic [15:0] off);
    return pc + 32'd4 + {{14{off[15]}}, off, 2'b00};
  endfunction

  task automatic t_reset();
    rstN = 0; setIdle();
    repeat (2) @(posedge clk);
    #1 chk("R1 reset vector", pcOut, 32'h0040_0000);
    @(negedge clk); rstN = 1;
    expPc = 32'h0040_0000;
  endtask

  task automatic t_sequential();
    for (int i = 0; i < 3; i++) stepExpect("R2 sequential", expPc + 32'd4);
  endtask

  task automatic t_branches();
    isBeq = 1; regsEqual = 1; instrImm16 = 16'h0005;
    stepExpect("R3 beq taken forward", brTarget(expPc, 16'h0005));
    isBeq = 1; regsEqual = 0; instrImm16 = 16'h0040;
    stepExpect("R4 beq untaken", expPc + 32'd4);
    isBne = 1; regsEqual = 1; instrImm16 = 16'h0040;
    stepExpect("R4 bne untaken", expPc + 32'd4);
    isBne = 1; regsEqual = 0; instrImm16 = 16'hFFFA;
    stepExpect("R3 bne taken backward", brTarget(expPc, 16'hFFFA));
  endtask

  task automatic t_jump();
    isJump = 1; instrIdx26 = 26'h012_3456;
    stepExpect("R5 jump target", {expPc[31:28] + 4'd0, 26'h012_3456, 2'b00});
  endtask

  task automatic t_jal();
    logic [31:0] p4;
    p4 = expPc + 32'd4;
    isJal = 1; instrIdx26 = 26'h000_0100;
    #1;
    chk("R6 link strobe", {31'd0, linkWrite}, 32'd1);
    chk("R6 link value", linkValue, p4);
    chk("R6 link dest", {27'd0, linkDest}, 32'd31);
    stepExpect("R6 jal target", {p4[31:28], 26'h000_0100, 2'b00});
    #1 chk("R6 strobe low after", {31'd0, linkWrite}, 32'd0);
  endtask

  task automatic t_jr();
    isJr = 1; regTarget = 32'h0040_1000;
    stepExpect("R7 jr target", 32'h0040_1000);
  endtask

  task automatic t_misaligned();
    isJr = 1; regTarget = 32'h0040_2002;
    #1;
    chk("R8 fault flag", {31'd0, alignFault}, 32'd1);
    stepExpect("R8 pc held", expPc);
    #1 chk("R8 fault clears", {31'd0, alignFault}, 32'd0);
    isJr = 1; isJal = 1; regTarget = 32'h0040_3001;
    #1 chk("R8 no link on fault", {31'd0, linkWrite}, 32'd0);
    stepExpect("R8 pc held with jal", expPc);
  endtask

  task automatic t_priority();
    isJr = 1; isJump = 1; isBeq = 1; regsEqual = 1;
    regTarget = 32'h0040_4000; instrIdx26 = 26'h000_0777; instrImm16 = 16'h0003;
    stepExpect("R9 jr beats jump and branch", 32'h0040_4000);
    isJump = 1; isBne = 1; regsEqual = 0;
    instrIdx26 = 26'h000_0888; instrImm16 = 16'h0003;
    stepExpect("R9 jump beats branch", {expPc[31:28], 26'h000_0888, 2'b00});
    isJal = 1; isJr = 1; regTarget = 32'h0040_5000; instrIdx26 = 26'h000_0999;
    #1 chk("R9 jal loses no link", {31'd0, linkWrite}, 32'd0);
    stepExpect("R9 jr beats jal", 32'h0040_5000);
  endtask

  task automatic t_region_edge();
    isJr = 1; regTarget = 32'h0FFF_FFFC;
    stepExpect("R7 jr to region end", 32'h0FFF_FFFC);
    isJump = 1; instrIdx26 = 26'h000_0010;
    stepExpect("R5 upper bits from pc+4", 32'h1000_0040);
  endtask

  task automatic t_reset_mid();
    rstN = 0;
    @(posedge clk); #1;
    chk("R1 reset mid run", pcOut, 32'h0040_0000);
    @(negedge clk); rstN = 1; expPc = 32'h0040_0000;
    stepExpect("R2 after reset", 32'h0040_0004);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    setIdle();
    @(negedge clk);
    t_reset();
    t_sequential();
    t_branches();
    t_jump();
    t_jal();
    t_jr();
    t_misaligned();
    t_priority();
    t_region_edge();
    t_reset_mid();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule